// File: doc/BRIEF.md
# Fallback Vertex Attribute Table Loader

This block holds sixteen four-component vectors that a vertex fetch stage uses as fallback inputs when an attribute has no memory stream behind it. Each component is a raw 24-bit floating-point pattern. No arithmetic is done on it here. Software fills the table through a word-addressed register bus. It first writes a slot pointer. It then writes three 32-bit words that together carry the 96 bits of one vector.

The loader keeps the first two words in a small staging buffer. When the third word arrives, it splits the 96 bits into four components. The first word carries the highest component, so the order runs from w down to x. The vector is written to the slot the pointer names, and the pointer then steps to the next slot. A long run of vectors can therefore be loaded after a single pointer write. If the pointer lies past the table when a vector completes, the vector is dropped and a one-cycle error pulse is raised. A combinational read port returns any stored entry.

Top module: `attr_default_loader`

## Requirements
- R1: After reset, the slot pointer `curIdx` is 0, `errFlag` is 0, the staging count is 0 and every table entry reads as all zeros.
- R2: A write to address `REG_BASE` (default 0x232) with lane 0 of `wrMask` enabled loads `curIdx` from `wrData[7:0]` on that clock edge. If lane 0 is disabled, `curIdx` is left unchanged.
- R3: A write to any of the addresses `REG_BASE+1` to `REG_BASE+3` is a data write. Data writes fill staging slots 0, 1 and 2 in arrival order; the address used does not select the slot. The table changes only on the edge of the third data write.
- R4: For staged words a (first), b (second) and c (third), the stored vector holds x = c[23:0] in bits 23:0, y = {b[15:0], c[31:24]} in bits 47:24, z = {a[7:0], b[31:16]} in bits 71:48, and w = a[31:8] in bits 95:72.
- R5: Each stored vector increments `curIdx` by one on the same edge.
- R6: If `curIdx` is 16 or more when the third data write arrives, the table and `curIdx` stay unchanged. `errFlag` is high for exactly the next cycle, and the staging count still returns to 0.
- R7: A data write updates only the byte lanes enabled in `wrMask`. Disabled lanes keep whatever that staging slot last held: zero after reset, or the bytes left there by an earlier vector.
- R8: A write to the pointer address returns the staging count to 0, whatever the state of its mask, so any partly staged vector is abandoned.
- R9: A write to any address outside `REG_BASE` to `REG_BASE+3` changes neither `curIdx` nor the staging count.
- R10: `rdVec` shows the entry selected by `rdIdx` in the same cycle, and a commit becomes visible there from the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W (10) | Word address of the write |
| wrData | input | 32 | Write data |
| wrMask | input | 4 | Byte-lane enables for the write |
| rdIdx | input | $clog2(NUM_ENTRIES) (4) | Table entry to read |
| rdVec | output | 96 | Selected entry {w, z, y, x} |
| curIdx | output | 8 | Current slot pointer |
| errFlag | output | 1 | One-cycle pulse when a completed vector is dropped |

## Verification
The bench uses the defaults: a 10-bit address bus with the base at 0x232 and sixteen entries. With these values, the 8-bit pointer can be walked from 15 to 16, and pointer values far past the table, such as 200, can be written directly. The out-of-range drop and its error pulse can therefore be reached both by auto-increment and by an explicit pointer write. Addresses one below the base and one above the last data register are also in range, so stray writes next to the window can be driven and shown to be ignored.

// File: rtl/attr_ldr_pkg.sv
package attr_ldr_pkg;

  localparam int COMP_W    = 24;
  localparam int WORD_W    = 32;
  localparam int NUM_COMP  = 4;
  localparam int VEC_W     = COMP_W * NUM_COMP;
  localparam int LANES     = WORD_W / 8;
  localparam int IDX_REG_W = 8;
  localparam int STAGE_N   = 3;

  typedef struct packed {
    logic       idxLoad;
    logic       stageWr;
    logic [1:0] slot;
    logic       commit;
  } ldrStrobe_t;

  function automatic logic [WORD_W-1:0] mergeBytes(
    input logic [WORD_W-1:0] oldW,
    input logic [WORD_W-1:0] newW,
    input logic [LANES-1:0]  mask
  );
    logic [WORD_W-1:0] res;
    for (int b = 0; b < LANES; b++) begin
      res[b*8 +: 8] = mask[b] ? newW[b*8 +: 8] : oldW[b*8 +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/attr_ldr_ctrl.sv
module attr_ldr_ctrl
  import attr_ldr_pkg::*;
#(
  parameter int          ADDR_W      = 10,
  parameter int unsigned REG_BASE    = 'h232,
  parameter int          NUM_ENTRIES = 16,
  localparam int         TBL_IDX_W   = $clog2(NUM_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [7:0]           wrLowByte,
  input  logic                 wrLane0,
  output ldrStrobe_t           strobe,
  output logic [TBL_IDX_W-1:0] commitIdx,
  output logic [IDX_REG_W-1:0] curIdx,
  output logic                 errFlag
);

  localparam logic [ADDR_W-1:0] IDX_ADDR   = ADDR_W'(REG_BASE);
  localparam logic [ADDR_W-1:0] DATA_FIRST = ADDR_W'(REG_BASE + 1);
  localparam logic [ADDR_W-1:0] DATA_LAST  = ADDR_W'(REG_BASE + STAGE_N);
  localparam logic [IDX_REG_W-1:0] LIMIT   = IDX_REG_W'(NUM_ENTRIES);

  logic [1:0]           slotQ;
  logic [IDX_REG_W-1:0] idxQ;
  logic                 errQ;
  logic                 isIdx, isData, lastWr, idxValid;

  assign isIdx    = wrEn && (wrAddr == IDX_ADDR);
  assign isData   = wrEn && (wrAddr >= DATA_FIRST) && (wrAddr <= DATA_LAST);
  assign lastWr   = isData && (slotQ == 2'(STAGE_N - 1));
  assign idxValid = idxQ < LIMIT;

  always_comb begin
    strobe.idxLoad = isIdx && wrLane0;
    strobe.stageWr = isData;
    strobe.slot    = slotQ;
    strobe.commit  = lastWr && idxValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotQ <= '0;
      idxQ  <= '0;
      errQ  <= 1'b0;
    end else begin
      errQ <= lastWr && !idxValid;
      if (isIdx) begin
        slotQ <= '0;
        if (wrLane0) idxQ <= wrLowByte[IDX_REG_W-1:0];
      end else if (isData) begin
        slotQ <= lastWr ? 2'd0 : slotQ + 2'd1;
        if (lastWr && idxValid) idxQ <= idxQ + 1'b1;
      end
    end
  end

  assign commitIdx = idxQ[TBL_IDX_W-1:0];
  assign curIdx    = idxQ;
  assign errFlag   = errQ;

endmodule

// File: rtl/attr_ldr_datapath.sv
module attr_ldr_datapath
  import attr_ldr_pkg::*;
#(
  parameter int  NUM_ENTRIES = 16,
  localparam int TBL_IDX_W   = $clog2(NUM_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ldrStrobe_t           strobe,
  input  logic [TBL_IDX_W-1:0] commitIdx,
  input  logic [WORD_W-1:0]    wrData,
  input  logic [LANES-1:0]     wrMask,
  input  logic [TBL_IDX_W-1:0] rdIdx,
  output logic [VEC_W-1:0]     rdVec
);

  logic [WORD_W-1:0] stageQ [STAGE_N];
  logic [WORD_W-1:0] slotOld, mergedWord;
  logic [COMP_W-1:0] compW, compZ, compY, compX;
  logic [VEC_W-1:0]  newVec;
  logic [VEC_W-1:0]  tblView [NUM_ENTRIES];

  always_comb begin
    case (strobe.slot)
      2'd1:    slotOld = stageQ[1];
      2'd2:    slotOld = stageQ[2];
      default: slotOld = stageQ[0];
    endcase
  end

  assign mergedWord = mergeBytes(slotOld, wrData, wrMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < STAGE_N; k++) stageQ[k] <= '0;
    end else if (strobe.stageWr) begin
      for (int k = 0; k < STAGE_N; k++) begin
        if (strobe.slot == 2'(k)) stageQ[k] <= mergedWord;
      end
    end
  end

  // Third word is taken straight from the bus merge so the commit needs no extra cycle.
  assign compW  = stageQ[0][31:8];
  assign compZ  = {stageQ[0][7:0], stageQ[1][31:16]};
  assign compY  = {stageQ[1][15:0], mergedWord[31:24]};
  assign compX  = mergedWord[23:0];
  assign newVec = {compW, compZ, compY, compX};

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    logic [VEC_W-1:0] entQ;
    always_ff @(posedge clk) begin
      if (!rstN) entQ <= '0;
      else if (strobe.commit && commitIdx == TBL_IDX_W'(e)) entQ <= newVec;
    end
    assign tblView[e] = entQ;
  end

  assign rdVec = tblView[rdIdx];

endmodule

// File: rtl/attr_default_loader.sv
module attr_default_loader
  import attr_ldr_pkg::*;
#(
  parameter int          ADDR_W      = 10,
  parameter int unsigned REG_BASE    = 'h232,
  parameter int          NUM_ENTRIES = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic [ADDR_W-1:0]                wrAddr,
  input  logic [31:0]                      wrData,
  input  logic [3:0]                       wrMask,
  input  logic [$clog2(NUM_ENTRIES)-1:0]   rdIdx,
  output logic [95:0]                      rdVec,
  output logic [7:0]                       curIdx,
  output logic                             errFlag
);

  localparam int TBL_IDX_W = $clog2(NUM_ENTRIES);

  ldrStrobe_t           strobe;
  logic [TBL_IDX_W-1:0] commitIdx;

  attr_ldr_ctrl #(
    .ADDR_W(ADDR_W), .REG_BASE(REG_BASE), .NUM_ENTRIES(NUM_ENTRIES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrLowByte(wrData[7:0]), .wrLane0(wrMask[0]),
    .strobe(strobe), .commitIdx(commitIdx), .curIdx(curIdx), .errFlag(errFlag)
  );

  attr_ldr_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .commitIdx(commitIdx),
    .wrData(wrData), .wrMask(wrMask), .rdIdx(rdIdx), .rdVec(rdVec)
  );

endmodule

// File: rtl/attr_default_loader_chk.sv
module attr_default_loader_chk
  import attr_ldr_pkg::*;
#(
  parameter int          ADDR_W      = 10,
  parameter int unsigned REG_BASE    = 'h232,
  parameter int          NUM_ENTRIES = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [31:0]       wrData,
  input logic [3:0]        wrMask,
  input logic [7:0]        curIdx,
  input logic              errFlag,
  input ldrStrobe_t        strobe
);

  logic isIdx, isData, isStray;
  assign isIdx   = wrEn && (wrAddr == ADDR_W'(REG_BASE));
  assign isData  = wrEn && (wrAddr >= ADDR_W'(REG_BASE + 1)) && (wrAddr <= ADDR_W'(REG_BASE + 3));
  assign isStray = wrEn && !isIdx && !isData;

  assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    isIdx && wrMask[0] |=> curIdx == $past(wrData[7:0]));

  assert_idx_masked_R2: assert property (@(posedge clk) disable iff (!rstN)
    isIdx && !wrMask[0] |=> $stable(curIdx));

  assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.slot != 2'd3);

  assert_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> curIdx == $past(curIdx) + 8'd1);

  assert_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    isData && strobe.slot == 2'd2 && curIdx >= 8'(NUM_ENTRIES) |=> errFlag && $stable(curIdx) && strobe.slot == 2'd0);

  assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> $past(isData));

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    isIdx |=> strobe.slot == 2'd0);

  assert_stray_R9: assert property (@(posedge clk) disable iff (!rstN)
    isStray |=> $stable(curIdx) && $stable(strobe.slot));

endmodule

bind attr_default_loader attr_default_loader_chk #(
  .ADDR_W(ADDR_W), .REG_BASE(REG_BASE), .NUM_ENTRIES(NUM_ENTRIES)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .wrMask(wrMask), .curIdx(curIdx), .errFlag(errFlag), .strobe(strobe)
);

// File: tb/attr_default_loader_bench.sv
`timescale 1ns/1ps
module attr_default_loader_bench;

  localparam logic [9:0] BASE = 10'h232;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [9:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  wrMask = '0;
  logic [3:0]  rdIdx = '0;
  logic [95:0] rdVec;
  logic [7:0]  curIdx;
  logic        errFlag;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // Bench model built from the requirements
  int          mIdx = 0;
  int          mCnt = 0;
  bit          mErr = 1'b0;
  logic [31:0] mStage [3];
  logic [95:0] mTbl [16];

  always #2.5 clk = ~clk;

  attr_default_loader u_attr_default_loader (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrMask(wrMask), .rdIdx(rdIdx), .rdVec(rdVec), .curIdx(curIdx), .errFlag(errFlag)
  );

  // Stimulus rows: {pointer, word a, word b, word c}
  localparam logic [103:0] ROWS [5] = '{
    {8'd0,  32'h1234_5678, 32'h9ABC_DEF0, 32'h0F1E_2D3C},
    {8'd7,  32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF},
    {8'd12, 32'h0000_0001, 32'h8000_0000, 32'h0000_0080},
    {8'd3,  32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'hC3C3_C3C3},
    {8'd14, 32'h3F80_0000, 32'h4000_0040, 32'h4040_0000}
  };

  function automatic logic [31:0] mergeB(input logic [31:0] o, input logic [31:0] n, input logic [3:0] m);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = m[b] ? n[b*8 +: 8] : o[b*8 +: 8];
    return r;
  endfunction

  // R4 field layout
  function automatic logic [95:0] unpackVec(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    return {a[31:8], a[7:0], b[31:16], b[15:0], c[31:24], c[23:0]};
  endfunction

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [9:0] a, input logic [31:0] d, input logic [3:0] m);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; wrMask = m;
    @(negedge clk);
    wrEn = 1'b0;
    mErr = 1'b0;
    if (a == BASE) begin
      mCnt = 0;
      if (m[0]) mIdx = d[7:0];
    end else if (a >= BASE + 10'd1 && a <= BASE + 10'd3) begin
      mStage[mCnt] = mergeB(mStage[mCnt], d, m);
      if (mCnt == 2) begin
        mCnt = 0;
        if (mIdx < 16) begin
          mTbl[mIdx] = unpackVec(mStage[0], mStage[1], mStage[2]);
          mIdx++;
        end else mErr = 1'b1;
      end else mCnt++;
    end
  endtask

  task automatic checkState(input string req);
    chk({req, " curIdx"}, 96'(curIdx), 96'(mIdx[7:0]));
    chk({req, " errFlag"}, 96'(errFlag), 96'(mErr));
  endtask

  task automatic checkEntry(input string req, input int e);
    rdIdx = 4'(e);
    #0.5;
    chk($sformatf("%s entry %0d", req, e), rdVec, mTbl[e]);
  endtask

  task automatic checkAll(input string req);
    int mism = 0;
    for (int e = 0; e < 16; e++) begin
      rdIdx = 4'(e);
      #0.1;
      if (rdVec !== mTbl[e]) mism++;
    end
    chk({req, " whole table mismatches"}, 96'(mism), 96'd0);
  endtask

  initial begin
    for (int k = 0; k < 3; k++) mStage[k] = '0;
    for (int e = 0; e < 16; e++) mTbl[e] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    checkState("R1");
    checkAll("R1");

    // Table-driven walk: R3 R4 R5 R10
    for (int r = 0; r < 5; r++) begin
      busWrite(BASE, 32'(ROWS[r][103:96]), 4'hF);
      busWrite(BASE + 10'd1, ROWS[r][95:64], 4'hF);
      busWrite(BASE + 10'd3, ROWS[r][63:32], 4'hF);
      checkEntry("R3 no commit before third word", int'(ROWS[r][103:96]));
      busWrite(BASE + 10'd2, ROWS[r][31:0], 4'hF);
      checkState("R5");
      checkEntry("R4", int'(ROWS[r][103:96]));
    end

    // R5: back-to-back vectors after one pointer write
    busWrite(BASE, 32'd5, 4'h1);
    for (int v = 0; v < 6; v++) busWrite(BASE + 10'd1, 32'hC0DE_0000 + 32'(v), 4'hF);
    checkState("R5 auto increment");
    checkEntry("R5", 5);
    checkEntry("R5", 6);

    // R2: masked pointer write leaves pointer
    busWrite(BASE, 32'h0000_0009, 4'hE);
    checkState("R2 lane0 disabled");
    busWrite(BASE, 32'hFFFF_FF0A, 4'h1);
    checkState("R2 load");

    // R8: partial vector abandoned by pointer write
    busWrite(BASE + 10'd1, 32'hDEAD_BEEF, 4'hF);
    busWrite(BASE + 10'd1, 32'hFEED_FACE, 4'hF);
    busWrite(BASE, 32'd11, 4'h0);
    busWrite(BASE + 10'd1, 32'h1111_1111, 4'hF);
    busWrite(BASE + 10'd1, 32'h2222_2222, 4'hF);
    busWrite(BASE + 10'd1, 32'h3333_3333, 4'hF);
    checkState("R8 restart");
    checkEntry("R8", 10);

    // R9: stray writes on both sides of the window
    busWrite(BASE, 32'd2, 4'hF);
    busWrite(BASE + 10'd1, 32'h0A0B_0C0D, 4'hF);
    busWrite(BASE - 10'd1, 32'h7777_7777, 4'hF);
    busWrite(BASE + 10'd4, 32'h8888_8888, 4'hF);
    checkState("R9 stray");
    busWrite(BASE + 10'd1, 32'h1A1B_1C1D, 4'hF);
    busWrite(BASE + 10'd1, 32'h2A2B_2C2D, 4'hF);
    checkEntry("R9", 2);

    // R7: partial byte lanes keep older staging bytes
    busWrite(BASE, 32'd9, 4'hF);
    busWrite(BASE + 10'd1, 32'h0000_00AA, 4'h1);
    busWrite(BASE + 10'd2, 32'hBB00_0000, 4'h8);
    busWrite(BASE + 10'd3, 32'h00CC_DD00, 4'h6);
    checkEntry("R7 byte mask", 9);
    checkState("R7");

    // R6: walk past the end, then an explicit far pointer
    busWrite(BASE, 32'd15, 4'hF);
    for (int v = 0; v < 3; v++) busWrite(BASE + 10'd2, 32'h5555_0000 + 32'(v), 4'hF);
    checkState("R6 last slot");
    for (int v = 0; v < 3; v++) busWrite(BASE + 10'd2, 32'h6666_0000 + 32'(v), 4'hF);
    checkState("R6 drop pulse");
    @(negedge clk);
    mErr = 1'b0;
    checkState("R6 pulse ends");
    busWrite(BASE, 32'd200, 4'hF);
    for (int v = 0; v < 3; v++) busWrite(BASE + 10'd3, 32'h9999_0000 + 32'(v), 4'hF);
    checkState("R6 far pointer");
    checkAll("R6 table untouched");
    // staging count back at zero after drop: next three words fill a vector
    busWrite(BASE, 32'd1, 4'hF);
    for (int v = 0; v < 3; v++) busWrite(BASE + 10'd1, 32'h4242_0000 + 32'(v), 4'hF);
    checkEntry("R6 count reset", 1);

    // R10: read port sweeps all entries
    checkAll("R10");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule